// File: doc/BRIEF.md
# Isolated Channel Receive Decoder

This block sits on the receive side of one isolated data channel. The transmit side sends a narrow pulse on one line to mark a high level and a narrow pulse on another line to mark a low level. A set/reset latch rebuilds the logic level from these pulses.

A watchdog measures how many cycles have passed since the last valid pulse. When the gap reaches a limit, the block decides that the transmit side has lost power. It reports this on a status output and drives a fixed default level until pulses return.

An active-high enable gates the output. When the enable is off, the output is treated as high impedance, and a flag shows whether the pin is driven. An enable that is not connected is taken as high. All times are parameters counted in clock cycles.

Top module: `iso_rx_decoder`

## Requirements
- R1: A set pulse alone (set_pulse=1, clr_pulse=0) makes the latched level 1 at the next clock edge.
- R2: A reset pulse alone (clr_pulse=1, set_pulse=0) makes the latched level 0 at the next clock edge.
- R3: In a cycle with no pulse, the latched level keeps its value, and data_out shows that value while driven and not idle.
- R4: If set_pulse and clr_pulse are both 1 in the same cycle, the latched level is unchanged. proto_err is 1 for exactly the following cycle. Such a cycle does not count as a valid pulse.
- R5: link_idle becomes 1 after WDOG_CYCLES consecutive clock edges with no valid pulse. While link_idle is 1 and the output is driven, data_out equals DEFAULT_LEVEL (1).
- R6: The first valid pulse after a timeout does two things at the same edge: it clears link_idle, and it loads the latched level from that pulse, so data_out shows the true level at once.
- R7: The effective enable passes through OE_STAGES registers to drive_en. While drive_en is 0, data_out is 0 (high impedance), whatever the pulses or the watchdog state.
- R8: With oe_floating=1 the enable is taken as high, whatever the value of oe_req.
- R9: During and right after reset: drive_en=0, data_out=0, link_idle=0, proto_err=0, and the latched level equals DEFAULT_LEVEL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_pulse | input | 1 | One-cycle pulse marking a high level |
| clr_pulse | input | 1 | One-cycle pulse marking a low level |
| oe_req | input | 1 | Active-high output enable |
| oe_floating | input | 1 | 1 when the enable pin is unconnected (behaves as high) |
| data_out | output | 1 | Decoded level; 0 while not driven |
| drive_en | output | 1 | 1 when data_out is driven, 0 for high impedance |
| link_idle | output | 1 | Watchdog judges the transmit side inactive |
| proto_err | output | 1 | One-cycle flag after a set/reset collision |

## Verification
The hardest state to reach from the ports is the edge of the watchdog window. The bench must tell apart a gap of exactly WDOG_CYCLES-1 edges from a gap of WDOG_CYCLES edges, and check a recovery pulse that arrives in the very first cycle after the timeout. A second hard case is a collision cycle that falls inside such a gap.

The bench handles these with a small watchdog limit. It sweeps every gap length from zero to past the limit, follows each gap with a set pulse or a reset pulse, and places collisions inside the gaps. It then runs a long pseudo-random phase whose pulse density switches between busy and quiet stretches. The expected value of every output is computed each cycle from the requirements.

// File: rtl/iso_rx_decoder.sv
module iso_rx_decoder #(
  parameter int WDOG_CYCLES   = 625,
  parameter int OE_STAGES     = 2,
  parameter bit DEFAULT_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_pulse,
  input  logic clr_pulse,
  input  logic oe_req,
  input  logic oe_floating,
  output logic data_out,
  output logic drive_en,
  output logic link_idle,
  output logic proto_err
);
  localparam int CW = $clog2(WDOG_CYCLES + 1);
  localparam logic [CW-1:0] WD_MAX = CW'(WDOG_CYCLES);

  logic          latch_q;
  logic [CW-1:0] quiet_cnt;
  logic          clash_q;
  logic [OE_STAGES-1:0] oe_pipe;

  wire valid  = set_pulse ^ clr_pulse;
  wire clash  = set_pulse & clr_pulse;
  wire oe_eff = oe_floating | oe_req;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     latch_q <= DEFAULT_LEVEL;
    else if (valid) latch_q <= set_pulse;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 quiet_cnt <= '0;
    else if (valid)             quiet_cnt <= '0;
    else if (quiet_cnt != WD_MAX) quiet_cnt <= quiet_cnt + CW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) clash_q <= 1'b0;
    else        clash_q <= clash;

  generate
    if (OE_STAGES == 1) begin : g_oe_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) oe_pipe <= '0;
        else        oe_pipe <= oe_eff;
    end else begin : g_oe_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) oe_pipe <= '0;
        else        oe_pipe <= {oe_pipe[OE_STAGES-2:0], oe_eff};
    end
  endgenerate

  assign link_idle = (quiet_cnt == WD_MAX);
  assign drive_en  = oe_pipe[OE_STAGES-1];
  assign data_out  = drive_en & (link_idle ? DEFAULT_LEVEL : latch_q);
  assign proto_err = clash_q;
endmodule

// File: rtl/iso_rx_decoder_chk.sv
module iso_rx_decoder_chk #(
  parameter int WDOG_CYCLES = 625
) (
  input logic clk,
  input logic rst_n,
  input logic set_pulse,
  input logic clr_pulse,
  input logic latch_q,
  input logic link_idle,
  input logic proto_err
);
  localparam int CW = $clog2(WDOG_CYCLES + 1);
  logic [CW-1:0] gap_c;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                           gap_c <= '0;
    else if (set_pulse ^ clr_pulse)       gap_c <= '0;
    else if (gap_c != CW'(WDOG_CYCLES))   gap_c <= gap_c + CW'(1);

  assert_set_hi_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (set_pulse && !clr_pulse) |=> latch_q);
  assert_clr_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pulse && !set_pulse) |=> !latch_q);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_pulse && !clr_pulse) |=> $stable(latch_q));
  assert_clash_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_pulse && clr_pulse) |=> ($stable(latch_q) && proto_err));
  assert_wdog_R5: assert property (@(posedge clk) disable iff (!rst_n)
    link_idle == (gap_c == CW'(WDOG_CYCLES)));
  assert_recover_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_pulse ^ clr_pulse) |=> (!link_idle && latch_q == $past(set_pulse)));
endmodule

bind iso_rx_decoder iso_rx_decoder_chk #(.WDOG_CYCLES(WDOG_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .set_pulse(set_pulse), .clr_pulse(clr_pulse),
  .latch_q(latch_q), .link_idle(link_idle), .proto_err(proto_err)
);

// File: tb/iso_rx_decoder_test.sv
`timescale 1ns/1ps
module iso_rx_decoder_test;
  localparam int W  = 12;
  localparam int OS = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic set_pulse = 0, clr_pulse = 0, oe_req = 0, oe_floating = 0;
  logic data_out, drive_en, link_idle, proto_err;
  int compared = 0, mismatched = 0;

  // model state
  bit m_q = 1'b1;
  int m_gap = 0;
  bit m_err = 0;
  bit [OS-1:0] m_pipe = '0;

  always #4 clk = ~clk;

  iso_rx_decoder #(.WDOG_CYCLES(W), .OE_STAGES(OS), .DEFAULT_LEVEL(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .set_pulse(set_pulse), .clr_pulse(clr_pulse),
    .oe_req(oe_req), .oe_floating(oe_floating), .data_out(data_out),
    .drive_en(drive_en), .link_idle(link_idle), .proto_err(proto_err));

  task automatic cmp(input string tag, input string what, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    bit drv, idl, dout;
    string tg;
    drv  = m_pipe[OS-1];
    idl  = (m_gap == W);
    dout = drv & (idl ? 1'b1 : m_q);
    tg = !drv ? "R7" : (idl ? "R5" : "R3");
    cmp("R7", "drive_en", drive_en, drv);
    cmp("R5", "link_idle", link_idle, idl);
    cmp("R4", "proto_err", proto_err, m_err);
    cmp(tg, "data_out", data_out, dout);
  endtask

  // apply inputs at negedge, advance one edge, update model, check at next negedge
  task automatic step(input bit s, input bit c, input bit oe, input bit fl);
    set_pulse = s; clr_pulse = c; oe_req = oe; oe_floating = fl;
    @(negedge clk);
    if (s ^ c) begin m_q = s; m_gap = 0; end
    else if (m_gap < W) m_gap++;
    m_err = s & c;
    m_pipe = {m_pipe[OS-2:0], oe | fl};
    check_all();
  endtask

  initial begin
    #(8 * 150000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    bit [15:0] lf;
    repeat (3) @(negedge clk);
    // R9 reset state
    cmp("R9", "drive_en", drive_en, 1'b0);
    cmp("R9", "data_out", data_out, 1'b0);
    cmp("R9", "link_idle", link_idle, 1'b0);
    cmp("R9", "proto_err", proto_err, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all();
    // R7: enable takes OS edges
    oe_req = 1;
    step(0, 0, 1, 0);
    cmp("R7", "drive_en after one edge", drive_en, 1'b0);
    step(0, 0, 1, 0);
    cmp("R7", "drive_en after two edges", drive_en, 1'b1);
    cmp("R9", "data_out default level", data_out, 1'b1);
    // R2, R1, R3
    step(0, 1, 1, 0); cmp("R2", "data_out after clr", data_out, 1'b0);
    step(0, 0, 1, 0); cmp("R3", "hold low", data_out, 1'b0);
    step(1, 0, 1, 0); cmp("R1", "data_out after set", data_out, 1'b1);
    step(0, 0, 1, 0); cmp("R3", "hold high", data_out, 1'b1);
    step(0, 1, 1, 0);
    // R4 collision
    step(1, 1, 1, 0);
    cmp("R4", "proto_err", proto_err, 1'b1);
    cmp("R4", "level kept", data_out, 1'b0);
    step(0, 0, 1, 0);
    cmp("R4", "proto_err one cycle", proto_err, 1'b0);
    // R5/R6 gap sweep, with and without a collision in the gap
    for (int g = 0; g <= W + 2; g++) begin
      for (int v = 0; v < 4; v++) begin
        step(0, 1, 1, 0);
        for (int k = 0; k < g; k++)
          step((v[1] && k == g / 2) ? 1'b1 : 1'b0, (v[1] && k == g / 2) ? 1'b1 : 1'b0, 1, 0);
        cmp("R5", "idle at gap", link_idle, (g >= W) ? 1'b1 : 1'b0);
        step(v[0], ~v[0], 1, 0);
        cmp("R6", "recovered level", data_out, v[0]);
        cmp("R6", "idle cleared", link_idle, 1'b0);
      end
    end
    // R7 disable masks idle default and latch
    step(1, 0, 0, 0);
    step(0, 0, 0, 0);
    cmp("R7", "data_out when disabled", data_out, 1'b0);
    for (int k = 0; k < W + 2; k++) step(0, 0, 0, 0);
    cmp("R7", "idle but disabled", data_out, 1'b0);
    // R8 floating enable
    step(0, 0, 0, 1);
    step(0, 0, 0, 1);
    cmp("R8", "floating enable drives", drive_en, 1'b1);
    cmp("R8", "floating default level", data_out, 1'b1);
    step(0, 1, 0, 1);
    cmp("R8", "floating follows clr", data_out, 1'b0);
    // pseudo-random phase
    lf = 16'hACE1;
    for (int n = 0; n < 6000; n++) begin
      bit quiet;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      quiet = (n / 200) % 2 == 1;
      step(quiet ? (lf[3:0] == 0) : lf[0], quiet ? (lf[7:4] == 0) : lf[1],
           lf[9:2] != 0, lf[15:11] == 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule